// File: doc/BRIEF.md
# Input Zero-Padding Loader

The loader sits between an on-chip feature-map buffer and the column FIFO that feeds a convolution kernel unit. Each load step takes one buffer word of four pixels and writes a five-register window toward the FIFO. The padding zeros are produced at this point, so a padded feature map never has to exist in external memory. The loader chooses one of four write-select cases for each step. The choice depends on the kernel mode and on where the step lies: which slice band it is in, which column and which word. In a step that supplies only zeros, the read enable toward the buffer is suppressed, so the buffer is not read.

A slice is started with a one-cycle `slice_start_i` pulse. That pulse captures the kernel mode and the slice position: the current band index against the total band count. The controller then raises `ctrl_rd_en_i` once per load step. Each slice contains an optional left zero column, then `COLS` data columns, then an optional right zero column. Every column is `WORDS` steps long. In the top band, the data columns begin with a single leading zero. The pixel that this zero displaces from the window is carried into the next word of the column.

Top module: `pad_loader`

## Requirements
- R1: After reset, and until the first slice start, `win_o` is zero, `win_valid_o` is low, `wsel_o` is 0 and `buf_rd_en_o` stays low whatever `ctrl_rd_en_i` does.
- R2: A `slice_start_i` pulse clears the whole window, including the carried register, in the next cycle and drops `win_valid_o`. In a cycle where it coincides with `ctrl_rd_en_i`, it wins: no load step occurs and the buffer is not read.
- R3: `buf_rd_en_o` equals `ctrl_rd_en_i` AND an active slice AND no start pulse AND `wsel_o` not 0. The write-select encoding is 0 = all-zero, 1 = data then zero, 2 = zero then data, 3 = carry then data.
- R4: A step with select 0 writes zero into all five window registers.
- R5: A step with select 1 writes buffer pixel k (bits 8k+7..8k of `buf_word_i`) into window register k (bits 8k+7..8k of `win_o`) for k = 0..3, and writes zero into register 4.
- R6: A step with select 2 writes zero into register 0 and writes buffer pixel k into register k+1.
- R7: A step with select 3 writes the previous content of register 4 into register 0 and writes buffer pixel k into register k+1.
- R8: Kernel mode 0 (3x3, stride 1) has a zero column on both the left and the right. Mode 1 (3x3, stride 2) has a zero column on the left only. Modes 2 and 3 (1x1) have no zero columns. Every step in a zero column uses select 0. After the last step of the last column, the slice is over and further read enables have no effect.
- R9: In the top band (current index 0), in modes 0 and 1, a data column uses select 2 for its first word and select 3 for its remaining words. Every other data column uses select 1.
- R10: When the current index is greater than or equal to the total count, every step of the slice uses select 0. This produces the zero band below the map.
- R11: Changes to `mode_i`, `cur_iter_i` and `total_iter_i` between start pulses have no effect on the slice in progress.
- R12: `win_valid_o` is high in exactly the cycle after a load step. Outside a load step, `win_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slice_start_i | input | 1 | Starts a slice and captures mode and position |
| mode_i | input | 2 | Kernel mode (0: 3x3 s1, 1: 3x3 s2, 2/3: 1x1) |
| cur_iter_i | input | ITER_W | Current slice band index |
| total_iter_i | input | ITER_W | Number of slice bands in the map |
| ctrl_rd_en_i | input | 1 | Controller load-step request |
| buf_word_i | input | LANES*PIX_W | Buffer word, sampled in a step with a read |
| buf_rd_en_o | output | 1 | Gated buffer read enable |
| wsel_o | output | 2 | Write-select case of the current step |
| win_o | output | (LANES+1)*PIX_W | Five-register window toward the FIFO |
| win_valid_o | output | 1 | Window was written on the previous edge |

## Verification
Two functions can fall in the same cycle: a new slice start and a load step of the slice in progress. The start carries priority, since it clears the carry register. Random start pulses are dropped into running slices while `ctrl_rd_en_i` is held high. In those cycles the bench expects no buffer read, a cleared window and a low valid flag. A second overlap lies at the seam between columns. There a carry step and the zero-led first word of the next column must not mix. Continuous top-band slices check that the next column's register 0 is zero, and not the carried pixel.

// File: rtl/pad_pkg.sv
package pad_pkg;

  typedef enum logic [1:0] {
    WS_ZZ = 2'd0,
    WS_RZ = 2'd1,
    WS_ZR = 2'd2,
    WS_SR = 2'd3
  } wsel_e;

  localparam logic [1:0] KM_3S1 = 2'd0;
  localparam logic [1:0] KM_3S2 = 2'd1;

  function automatic logic has_left_pad(input logic [1:0] mode);
    return (mode == KM_3S1) || (mode == KM_3S2);
  endfunction

  function automatic logic has_right_pad(input logic [1:0] mode);
    return mode == KM_3S1;
  endfunction

endpackage

// File: rtl/pad_seq.sv
module pad_seq
  import pad_pkg::*;
#(
  parameter int WORDS  = 4,
  parameter int COLS   = 3,
  parameter int ITER_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              step_req_i,
  input  logic [1:0]        mode_i,
  input  logic [ITER_W-1:0] cur_i,
  input  logic [ITER_W-1:0] total_i,
  output wsel_e             sel_o,
  output logic              active_o,
  output logic              step_o
);

  localparam int WW = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int CW = $clog2(COLS + 2);

  logic          active_q;
  logic [1:0]    mode_q;
  logic          top_q;
  logic          ghost_q;
  logic [CW-1:0] col_q;
  logic [WW-1:0] word_q;

  logic          lpad, rpad, pad_col, last_word, last_col_hit;
  logic [CW-1:0] last_col;

  always_comb begin
    lpad         = has_left_pad(mode_q);
    rpad         = has_right_pad(mode_q);
    last_col     = CW'(COLS - 1) + CW'(lpad) + CW'(rpad);
    pad_col      = (lpad && col_q == '0) || (rpad && col_q == last_col);
    last_word    = (word_q == WW'(WORDS - 1));
    last_col_hit = (col_q == last_col);
  end

  always_comb begin
    if (!active_q || ghost_q || pad_col) sel_o = WS_ZZ;
    else if (top_q && lpad)              sel_o = (word_q == '0) ? WS_ZR : WS_SR;
    else                                 sel_o = WS_RZ;
  end

  assign step_o   = step_req_i && !start_i && active_q;
  assign active_o = active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      mode_q   <= '0;
      top_q    <= 1'b0;
      ghost_q  <= 1'b0;
      col_q    <= '0;
      word_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      mode_q   <= mode_i;
      top_q    <= (cur_i == '0);
      ghost_q  <= (cur_i >= total_i);
      col_q    <= '0;
      word_q   <= '0;
    end else if (step_o) begin
      if (last_word) begin
        word_q <= '0;
        if (last_col_hit) active_q <= 1'b0;
        else              col_q    <= col_q + 1'b1;
      end else begin
        word_q <= word_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pad_window.sv
module pad_window
  import pad_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int LANES = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clear_i,
  input  logic                       step_i,
  input  wsel_e                      sel_i,
  input  logic [LANES*PIX_W-1:0]     word_i,
  output logic [(LANES+1)*PIX_W-1:0] win_o,
  output logic                       valid_o
);

  localparam int REGS = LANES + 1;

  logic [PIX_W-1:0] win_q [REGS];
  logic [PIX_W-1:0] nxt   [REGS];

  for (genvar k = 0; k < REGS; k++) begin : g_reg
    logic [PIX_W-1:0] rz_val, sh_val;
    if (k < LANES) begin : g_rz
      assign rz_val = word_i[k*PIX_W +: PIX_W];
    end else begin : g_rz_tail
      assign rz_val = '0;
    end
    if (k > 0) begin : g_sh
      assign sh_val = word_i[(k-1)*PIX_W +: PIX_W];
    end else begin : g_sh_head
      // register 0: zero for a leading pad, carried tail pixel otherwise
      assign sh_val = (sel_i == WS_SR) ? win_q[LANES] : '0;
    end

    always_comb begin
      unique case (sel_i)
        WS_RZ:        nxt[k] = rz_val;
        WS_ZR, WS_SR: nxt[k] = sh_val;
        default:      nxt[k] = '0;
      endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      win_q[k] <= '0;
      else if (clear_i) win_q[k] <= '0;
      else if (step_i)  win_q[k] <= nxt[k];
    end

    assign win_o[k*PIX_W +: PIX_W] = win_q[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      valid_o <= 1'b0;
    else if (clear_i) valid_o <= 1'b0;
    else              valid_o <= step_i;
  end

endmodule

// File: rtl/pad_loader.sv
module pad_loader
  import pad_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int LANES  = 4,
  parameter int WORDS  = 4,
  parameter int COLS   = 3,
  parameter int ITER_W = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       slice_start_i,
  input  logic [1:0]                 mode_i,
  input  logic [ITER_W-1:0]          cur_iter_i,
  input  logic [ITER_W-1:0]          total_iter_i,
  input  logic                       ctrl_rd_en_i,
  input  logic [LANES*PIX_W-1:0]     buf_word_i,
  output logic                       buf_rd_en_o,
  output logic [1:0]                 wsel_o,
  output logic [(LANES+1)*PIX_W-1:0] win_o,
  output logic                       win_valid_o
);

  wsel_e sel;
  logic  active;
  logic  step;

  pad_seq #(
    .WORDS  (WORDS),
    .COLS   (COLS),
    .ITER_W (ITER_W)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (slice_start_i),
    .step_req_i (ctrl_rd_en_i),
    .mode_i     (mode_i),
    .cur_i      (cur_iter_i),
    .total_i    (total_iter_i),
    .sel_o      (sel),
    .active_o   (active),
    .step_o     (step)
  );

  pad_window #(
    .PIX_W (PIX_W),
    .LANES (LANES)
  ) u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (slice_start_i),
    .step_i  (step),
    .sel_i   (sel),
    .word_i  (buf_word_i),
    .win_o   (win_o),
    .valid_o (win_valid_o)
  );

  // zero-only steps never touch the buffer
  assign buf_rd_en_o = step && (sel != WS_ZZ);
  assign wsel_o      = sel;

endmodule

// File: rtl/pad_loader_chk.sv
module pad_loader_chk #(
  parameter int PIX_W = 8,
  parameter int LANES = 4
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       slice_start_i,
  input logic                       ctrl_rd_en_i,
  input logic [LANES*PIX_W-1:0]     buf_word_i,
  input logic                       buf_rd_en_o,
  input logic [1:0]                 wsel_o,
  input logic [(LANES+1)*PIX_W-1:0] win_o,
  input logic                       win_valid_o,
  input logic                       active
);

  localparam int WIN_W = (LANES + 1) * PIX_W;

  logic step_seen;
  assign step_seen = ctrl_rd_en_i && !slice_start_i && active;

  AST_RD_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_rd_en_o |-> (ctrl_rd_en_i && !slice_start_i)); // R3
  AST_NO_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wsel_o == 2'd0) |-> !buf_rd_en_o); // R3
  AST_IDLE_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> !buf_rd_en_o); // R8
  AST_ZZ_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_seen && wsel_o == 2'd0) |=> (win_o == '0)); // R4
  AST_RZ_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_seen && wsel_o == 2'd1) |=>
      (win_o[LANES*PIX_W +: PIX_W] == '0) && (win_o[LANES*PIX_W-1:0] == $past(buf_word_i))); // R5
  AST_ZR_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_seen && wsel_o == 2'd2) |=>
      (win_o[PIX_W-1:0] == '0) && (win_o[WIN_W-1:PIX_W] == $past(buf_word_i))); // R6
  AST_SR_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_seen && wsel_o == 2'd3) |=>
      (win_o[PIX_W-1:0] == $past(win_o[LANES*PIX_W +: PIX_W])) &&
      (win_o[WIN_W-1:PIX_W] == $past(buf_word_i))); // R7
  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slice_start_i |=> (win_o == '0) && !win_valid_o); // R2
  AST_VALID_AFTER_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_seen |=> win_valid_o); // R12
  AST_NO_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_seen |=> !win_valid_o && $stable(win_o) || $past(slice_start_i)); // R12

endmodule

bind pad_loader pad_loader_chk #(
  .PIX_W (PIX_W),
  .LANES (LANES)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .slice_start_i (slice_start_i),
  .ctrl_rd_en_i  (ctrl_rd_en_i),
  .buf_word_i    (buf_word_i),
  .buf_rd_en_o   (buf_rd_en_o),
  .wsel_o        (wsel_o),
  .win_o         (win_o),
  .win_valid_o   (win_valid_o),
  .active        (active)
);

// File: tb/pad_loader_test.sv
module pad_loader_test;

  localparam int PIX_W  = 8;
  localparam int LANES  = 4;
  localparam int WORDS  = 4;
  localparam int COLS   = 3;
  localparam int ITER_W = 4;
  localparam int WIN_W  = (LANES + 1) * PIX_W;

  logic                   clk_i = 1'b0;
  logic                   rst_ni;
  logic                   slice_start_i;
  logic [1:0]             mode_i;
  logic [ITER_W-1:0]      cur_iter_i, total_iter_i;
  logic                   ctrl_rd_en_i;
  logic [LANES*PIX_W-1:0] buf_word_i;
  logic                   buf_rd_en_o;
  logic [1:0]             wsel_o;
  logic [WIN_W-1:0]       win_o;
  logic                   win_valid_o;

  pad_loader #(
    .PIX_W(PIX_W), .LANES(LANES), .WORDS(WORDS), .COLS(COLS), .ITER_W(ITER_W)
  ) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .slice_start_i(slice_start_i), .mode_i(mode_i),
    .cur_iter_i(cur_iter_i), .total_iter_i(total_iter_i), .ctrl_rd_en_i(ctrl_rd_en_i),
    .buf_word_i(buf_word_i), .buf_rd_en_o(buf_rd_en_o), .wsel_o(wsel_o),
    .win_o(win_o), .win_valid_o(win_valid_o)
  );

  always #2 clk_i = ~clk_i;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // bench model state
  bit               m_active = 1'b0;
  logic [1:0]       m_mode   = '0;
  bit               m_top    = 1'b0;
  bit               m_ghost  = 1'b0;
  int               m_col    = 0;
  int               m_word   = 0;
  logic [WIN_W-1:0] m_win    = '0;
  bit               scramble = 1'b0;
  bit               in_reset_phase = 1'b0;

  function automatic bit lp(input logic [1:0] m); return (m == 2'd0) || (m == 2'd1); endfunction
  function automatic bit rp(input logic [1:0] m); return m == 2'd0; endfunction
  function automatic int ncols(input logic [1:0] m); return COLS + int'(lp(m)) + int'(rp(m)); endfunction
  function automatic bit on_pad_col();
    return (lp(m_mode) && m_col == 0) || (rp(m_mode) && m_col == ncols(m_mode) - 1);
  endfunction
  function automatic logic [1:0] exp_sel();
    if (!m_active || m_ghost || on_pad_col()) return 2'd0;
    if (m_top && lp(m_mode)) return (m_word == 0) ? 2'd2 : 2'd3;
    return 2'd1;
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // one cycle: drive after negedge, check combinational outputs, then registered ones
  task automatic cycle(input bit st, input bit rd, input logic [1:0] md,
                       input int cur, input int tot);
    logic [1:0]       es;
    bit               er, step;
    string            rq_sel, rq_win, rq_rd;
    logic [LANES*PIX_W-1:0] w;
    w = {$urandom(), $urandom()};
    slice_start_i = st;
    ctrl_rd_en_i  = rd;
    buf_word_i    = w;
    if (st || !scramble) begin
      mode_i = md; cur_iter_i = ITER_W'(cur); total_iter_i = ITER_W'(tot);
    end else begin
      mode_i = 2'($urandom()); cur_iter_i = ITER_W'($urandom()); total_iter_i = ITER_W'($urandom());
    end
    #1;
    es   = exp_sel();
    step = rd && !st && m_active;
    er   = step && (es != 2'd0);
    if (in_reset_phase)  rq_sel = "R1";
    else if (scramble)   rq_sel = "R11";
    else if (!m_active)  rq_sel = "R8";
    else if (m_ghost)    rq_sel = "R10";
    else if (on_pad_col()) rq_sel = "R8";
    else                 rq_sel = "R9";
    rq_rd = in_reset_phase ? "R1" : (st && rd ? "R2" : "R3");
    chk(rq_sel, "wsel_o", 64'(wsel_o), 64'(es));
    chk(rq_rd, "buf_rd_en_o", 64'(buf_rd_en_o), 64'(er));
    // model update
    if (st) begin
      m_active = 1'b1; m_mode = md; m_top = (cur == 0); m_ghost = (cur >= tot);
      m_col = 0; m_word = 0; m_win = '0; rq_win = "R2";
    end else if (step) begin
      case (es)
        2'd0: begin m_win = '0;                              rq_win = "R4"; end
        2'd1: begin m_win = {PIX_W'(0), w};                  rq_win = "R5"; end
        2'd2: begin m_win = {w, PIX_W'(0)};                  rq_win = "R6"; end
        default: begin m_win = {w, m_win[WIN_W-1 -: PIX_W]}; rq_win = "R7"; end
      endcase
      if (m_word == WORDS - 1) begin
        m_word = 0;
        if (m_col == ncols(m_mode) - 1) m_active = 1'b0;
        else m_col++;
      end else m_word++;
    end else begin
      rq_win = in_reset_phase ? "R1" : "R12";
    end
    @(negedge clk_i);
    chk(rq_win, "win_o", 64'(win_o), 64'(m_win));
    chk(in_reset_phase ? "R1" : "R12", "win_valid_o", 64'(win_valid_o), 64'(step && !st));
  endtask

  task automatic run_slice(input logic [1:0] md, input int cur, input int tot, input int n);
    cycle(1'b1, 1'b0, md, cur, tot);
    for (int i = 0; i < n; i++) cycle(1'b0, 1'b1, md, cur, tot);
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    void'($urandom(32'd20240419));
    rst_ni = 1'b0; slice_start_i = 1'b0; ctrl_rd_en_i = 1'b0;
    mode_i = '0; cur_iter_i = '0; total_iter_i = '0; buf_word_i = '0;
    repeat (3) @(negedge clk_i);
    chk("R1", "win_o in reset", 64'(win_o), 64'h0);
    rst_ni = 1'b1;
    // R1: read requests before any slice start do nothing
    in_reset_phase = 1'b1;
    for (int i = 0; i < 4; i++) cycle(1'b0, 1'b1, 2'd0, 0, 1);
    in_reset_phase = 1'b0;

    // directed: every mode against top, middle and below-map bands (R8 R9 R10)
    for (int md = 0; md < 4; md++) begin
      run_slice(2'(md), 0, 3, 24);
      run_slice(2'(md), 1, 3, 24);
      run_slice(2'(md), 3, 3, 24);
    end
    // single-band map: top and bottom at once
    run_slice(2'd0, 0, 1, 22);

    // collision: restart while steps are requested (R2)
    cycle(1'b1, 1'b0, 2'd0, 0, 2);
    for (int i = 0; i < 6; i++) cycle(1'b0, 1'b1, 2'd0, 0, 2);
    cycle(1'b1, 1'b1, 2'd1, 0, 2);
    for (int i = 0; i < 20; i++) cycle(1'b0, 1'b1, 2'd1, 0, 2);

    // random: gaps, stray restarts, scrambled inputs mid-slice (R11)
    scramble = 1'b1;
    for (int s = 0; s < 150; s++) begin
      logic [1:0] md;
      int tot, cur;
      md  = 2'($urandom_range(0, 3));
      tot = $urandom_range(1, 4);
      cur = $urandom_range(0, 4);
      cycle(1'b1, 1'($urandom_range(0, 1)), md, cur, tot);
      for (int i = 0; i < 30; i++) begin
        bit st;
        st = ($urandom_range(0, 39) == 0);
        cycle(st, ($urandom_range(0, 3) != 0), md, cur, tot);
      end
    end
    finished = 1'b1;
    summary();
  end

endmodule